// File: doc/BRIEF.md
# External Clock Switch Controller

This block holds the software-facing control for moving the system clock between the internal oscillator and an external source. A small write port reaches two registers. The control register holds a 4-bit source select and a 4-bit speed select. A one-bit unlock register can be closed by software and then stays closed until reset. A read-only 4-bit status field reports whether the move to the external source is complete.

The select field uses multi-bit booleans: 0x6 means true and 0x9 means false. It obeys a one-way rule. A write can only flip the field to the opposite boolean value, and every other written value leaves the field as it is. The request to the clock mux rises only while a debug-enable qualifier is high. The speed select matters only while that request is active: true keeps nominal speed, and any other value asks for the stepped-down, low-speed divider setting.

The mux and the dividers sit outside the block. They are reached through a request output and an acknowledge input.

Top module: `xclk_switch_ctrl`

## Requirements
- R1: After reset, the select and speed fields read 0x9, the unlock bit reads 1, the status reads 0x9, and both the request and the low-speed output are 0.
- R2: While the select reads 0x9, a control write (address 1, select in data[3:0]) of 0x6 sets it to 0x6 on the next clock. A write of any other value leaves it unchanged.
- R3: While the select reads 0x6, only a control write of 0x9 sets it back to 0x9. A write of any other value leaves it unchanged.
- R4: A control write accepted while unlocked stores data[7:4] into the speed field as written, whatever its value.
- R5: The request output equals, one clock late, (select is 0x6 AND debug-enable is high). Control writes are accepted whatever the state of debug-enable.
- R6: The low-speed output is high exactly when the request is high and the speed field is not 0x6.
- R7: A write to address 0 with data[0]=0 clears the unlock bit, and a write with data[0]=1 leaves it unchanged. Once the bit is cleared, it stays 0 until reset, and every control write is ignored.
- R8: The status becomes 0x6 on the clock after one where the request and the mux acknowledge are both high. It stays 0x9 while no acknowledged request has occurred.
- R9: Once the status is 0x6, it returns to 0x9 on the clock after one where the request and the acknowledge are both low. It holds its value while only one of the two is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | 0 = unlock register, 1 = control register |
| wr_data_i | input | 8 | Write data: [3:0] select, [7:4] speed; [0] for unlock register |
| dbg_en_i | input | 1 | Debug-enable qualifier |
| mux_ack_i | input | 1 | Acknowledge from clock mux |
| switch_req_o | output | 1 | Request for the external source |
| low_speed_o | output | 1 | Request for the stepped-down divider setting |
| status_o | output | 4 | Switch-complete status (0x6 true, 0x9 false) |
| sel_o | output | 4 | Current select field |
| speed_o | output | 4 | Current speed field |
| ctrl_unlocked_o | output | 1 | Unlock bit |

## Verification
Directed sequences write 0x6, 0x9 and invalid select codes in each state. This separates the one-way flip rule from a plain register, which would take every value. Further sequences toggle debug-enable while the select is true, which separates the gated request from a bare copy of the field. Acknowledge pulses are placed both with and without a live request, which separates a proper handshake from a status that simply follows the acknowledge. Long random runs, biased toward the two valid codes, mix writes, lock attempts, debug-enable changes and acknowledges against a bench model, and finish with writes after the lock has closed.

// File: rtl/xcs_pkg.sv
// Shared encodings for the external clock switch controller.
// Assumes 4-bit multi-bit booleans with fixed true/false codes.
package xcs_pkg;
    localparam int unsigned MUBI_W = 4;
    localparam int unsigned DATA_W = 2 * MUBI_W;
    typedef logic [MUBI_W-1:0] mubi_t;
    localparam mubi_t MUBI_TRUE  = 4'h6;
    localparam mubi_t MUBI_FALSE = 4'h9;

    // Strict test for the true code; every other value counts as not true.
    function automatic logic mubi_is_true(mubi_t v);
        return v == MUBI_TRUE;
    endfunction
endpackage

// File: rtl/xcs_lock.sv
// Write-unlock bit: resets open, closes on a write of zero, and stays closed until reset.
// Assumes clr_req_i is already qualified by the write strobe and address.
module xcs_lock (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_req_i,
    output logic unlocked_o
);
    // Sticky clear of the unlock bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)        unlocked_o <= 1'b1;
        else if (clr_req_i) unlocked_o <= 1'b0;
    end
endmodule

// File: rtl/xcs_select.sv
// Control register: a one-way multi-bit select plus a freely written speed field.
// Assumes we_i already carries the unlock qualification.
module xcs_select
    import xcs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  we_i,
    input  mubi_t sel_wdata_i,
    input  mubi_t spd_wdata_i,
    output mubi_t sel_o,
    output mubi_t spd_o
);
    logic  cur_true;
    mubi_t sel_next;

    // Flip only to the opposite valid code; every other value is ignored.
    always_comb begin
        cur_true = mubi_is_true(sel_o);
        sel_next = sel_o;
        if (!cur_true && sel_wdata_i == MUBI_TRUE)      sel_next = MUBI_TRUE;
        else if (cur_true && sel_wdata_i == MUBI_FALSE) sel_next = MUBI_FALSE;
    end

    // Register both fields on an accepted write.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sel_o <= MUBI_FALSE;
            spd_o <= MUBI_FALSE;
        end else if (we_i) begin
            sel_o <= sel_next;
            spd_o <= spd_wdata_i;
        end
    end
endmodule

// File: rtl/xcs_handshake.sv
// Request/acknowledge tracking toward the clock mux and the divider speed hint.
// Assumes the mux acknowledge is already synchronous to clk_i.
module xcs_handshake
    import xcs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  sel_true_i,
    input  logic  spd_true_i,
    input  logic  dbg_en_i,
    input  logic  mux_ack_i,
    output logic  req_o,
    output logic  low_speed_o,
    output mubi_t status_o
);
    logic done_q;

    // Request is the select gated by debug enable, registered once.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) req_o <= 1'b0;
        else         req_o <= sel_true_i && dbg_en_i;
    end

    // Completion sets on request+ack and clears only when both have dropped.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                       done_q <= 1'b0;
        else if (req_o && mux_ack_i)       done_q <= 1'b1;
        else if (!req_o && !mux_ack_i)     done_q <= 1'b0;
    end

    // Encode outputs.
    always_comb begin
        low_speed_o = req_o && !spd_true_i;
        status_o    = done_q ? MUBI_TRUE : MUBI_FALSE;
    end
endmodule

// File: rtl/xclk_switch_ctrl.sv
// Top of the external clock switch controller: write decode, lock, control register, handshake.
// Assumes a single-cycle write strobe; address 0 is the unlock bit, address 1 the control register.
module xclk_switch_ctrl
    import xcs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_valid_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              dbg_en_i,
    input  logic              mux_ack_i,
    output logic              switch_req_o,
    output logic              low_speed_o,
    output logic [MUBI_W-1:0] status_o,
    output logic [MUBI_W-1:0] sel_o,
    output logic [MUBI_W-1:0] speed_o,
    output logic              ctrl_unlocked_o
);
    logic lock_clr, ctrl_we;

    // Address decode for the two registers.
    always_comb begin
        lock_clr = wr_valid_i && !wr_addr_i && !wr_data_i[0];
        ctrl_we  = wr_valid_i && wr_addr_i && ctrl_unlocked_o;
    end

    xcs_lock i_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_req_i  (lock_clr),
        .unlocked_o (ctrl_unlocked_o)
    );

    xcs_select i_sel (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (ctrl_we),
        .sel_wdata_i (wr_data_i[MUBI_W-1:0]),
        .spd_wdata_i (wr_data_i[DATA_W-1:MUBI_W]),
        .sel_o       (sel_o),
        .spd_o       (speed_o)
    );

    xcs_handshake i_hs (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sel_true_i  (mubi_is_true(sel_o)),
        .spd_true_i  (mubi_is_true(speed_o)),
        .dbg_en_i    (dbg_en_i),
        .mux_ack_i   (mux_ack_i),
        .req_o       (switch_req_o),
        .low_speed_o (low_speed_o),
        .status_o    (status_o)
    );
endmodule

// File: rtl/xcs_checker.sv
// Port-level properties of the external clock switch controller, bound to the top.
module xcs_checker
    import xcs_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_valid_i,
    input logic              wr_addr_i,
    input logic              dbg_en_i,
    input logic              mux_ack_i,
    input logic              switch_req_o,
    input logic              low_speed_o,
    input logic [MUBI_W-1:0] status_o,
    input logic [MUBI_W-1:0] sel_o,
    input logic [MUBI_W-1:0] speed_o,
    input logic              ctrl_unlocked_o
);
    // R2 / R3: select holds a valid code and moves only on a control write.
    a_r2_sel_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o == MUBI_TRUE || sel_o == MUBI_FALSE);
    a_r3_sel_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_valid_i && wr_addr_i) |=> $stable(sel_o));
    // R5: a request never rises without debug enable in the prior cycle.
    a_r5_req_needs_dbg: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(switch_req_o) |-> $past(dbg_en_i));
    // R6: low speed only with an active request.
    a_r6_low_implies_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low_speed_o |-> switch_req_o);
    // R7: lock is sticky and freezes the control fields.
    a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_unlocked_o |=> !ctrl_unlocked_o);
    a_r7_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ctrl_unlocked_o |=> $stable(sel_o) && $stable(speed_o));
    // R8: status turns true only after an acknowledged request.
    a_r8_status_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(status_o == MUBI_TRUE) |-> $past(switch_req_o && mux_ack_i));
    // R9: status drops only after both request and acknowledge are low.
    a_r9_status_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o == MUBI_TRUE) |-> $past(!switch_req_o && !mux_ack_i));
endmodule

bind xclk_switch_ctrl xcs_checker i_xcs_checker (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_valid_i      (wr_valid_i),
    .wr_addr_i       (wr_addr_i),
    .dbg_en_i        (dbg_en_i),
    .mux_ack_i       (mux_ack_i),
    .switch_req_o    (switch_req_o),
    .low_speed_o     (low_speed_o),
    .status_o        (status_o),
    .sel_o           (sel_o),
    .speed_o         (speed_o),
    .ctrl_unlocked_o (ctrl_unlocked_o)
);

// File: tb/test_xclk_switch_ctrl.sv
module test_xclk_switch_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_addr = 1'b0, dbg_en = 1'b0, mux_ack = 1'b0;
    logic [7:0] wr_data = 8'h0;
    logic       req, low;
    logic [3:0] status, sel, spd;
    logic       unlocked;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Bench model state, derived from the requirements.
    logic       m_lock, m_req, m_ack;
    logic [3:0] m_sel, m_spd;
    logic       n_lock, n_req, n_ack;
    logic [3:0] n_sel, n_spd;

    always #10 clk = ~clk;

    xclk_switch_ctrl i_xclk_switch_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .dbg_en_i(dbg_en), .mux_ack_i(mux_ack),
        .switch_req_o(req), .low_speed_o(low), .status_o(status),
        .sel_o(sel), .speed_o(spd), .ctrl_unlocked_o(unlocked)
    );

    function automatic logic [3:0] sel_rule(logic [3:0] cur, logic [3:0] w);
        if (cur != 4'h6 && w == 4'h6) return 4'h6;
        if (cur == 4'h6 && w == 4'h9) return 4'h9;
        return cur;
    endfunction

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R2/R3 sel", sel, m_sel);
        chk("R4 speed", spd, m_spd);
        chk("R7 unlock", {3'b0, unlocked}, {3'b0, m_lock});
        chk("R5 request", {3'b0, req}, {3'b0, m_req});
        chk("R6 low_speed", {3'b0, low}, {3'b0, m_req && m_spd != 4'h6});
        chk("R8/R9 status", status, m_ack ? 4'h6 : 4'h9);
    endtask

    // Drive one cycle of inputs, advance the model, compare after the edge.
    task automatic step(logic wv, logic wa, logic [7:0] wd, logic de, logic ak);
        wr_valid = wv; wr_addr = wa; wr_data = wd; dbg_en = de; mux_ack = ak;
        n_lock = m_lock; n_sel = m_sel; n_spd = m_spd;
        if (wv && !wa && !wd[0]) n_lock = 1'b0;
        if (wv && wa && m_lock) begin
            n_sel = sel_rule(m_sel, wd[3:0]);
            n_spd = wd[7:4];
        end
        n_req = (m_sel == 4'h6) && de;
        n_ack = m_ack;
        if (m_req && ak) n_ack = 1'b1;
        else if (!m_req && !ak) n_ack = 1'b0;
        @(negedge clk);
        m_lock = n_lock; m_sel = n_sel; m_spd = n_spd; m_req = n_req; m_ack = n_ack;
        compare_all();
    endtask

    function automatic logic [3:0] pick_code();
        int r = $urandom_range(0, 9);
        if (r < 4) return 4'h6;
        if (r < 8) return 4'h9;
        return 4'($urandom_range(0, 15));
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lock = 1'b1; m_sel = 4'h9; m_spd = 4'h9; m_req = 1'b0; m_ack = 1'b0;
        // R1: reset state.
        chk("R1 sel", sel, 4'h9);
        chk("R1 speed", spd, 4'h9);
        chk("R1 status", status, 4'h9);
        chk("R1 req/low/unlock", {1'b0, req, low, unlocked}, 4'b0001);

        // R2: invalid codes do not arm; true does.
        step(1, 1, 8'h63, 1, 0);
        chk("R2 invalid ignored", sel, 4'h9);
        step(1, 1, 8'h66, 1, 0);
        chk("R2 true accepted", sel, 4'h6);
        step(0, 0, 8'h00, 1, 0);
        chk("R5 req after select", {3'b0, req}, 4'h1);
        chk("R6 nominal speed", {3'b0, low}, 4'h0);
        // R3: only false returns; R4 speed write lowers speed.
        step(1, 1, 8'h36, 1, 0);
        step(1, 1, 8'h3A, 1, 0);
        chk("R3 non-false ignored", sel, 4'h6);
        chk("R6 low speed", {3'b0, low}, 4'h1);
        // R8: acknowledge completes.
        step(0, 0, 8'h00, 1, 1);
        step(0, 0, 8'h00, 1, 1);
        chk("R8 status true", status, 4'h6);
        // R5: debug enable low drops request; write still accepted.
        step(1, 1, 8'h30, 0, 1);
        step(0, 0, 8'h00, 0, 1);
        chk("R5 req gated", {3'b0, req}, 4'h0);
        chk("R9 status held while ack high", status, 4'h6);
        step(0, 0, 8'h00, 0, 0);
        step(0, 0, 8'h00, 0, 0);
        chk("R9 status false", status, 4'h9);
        // R8: acknowledge without request does not complete.
        step(0, 0, 8'h00, 0, 1);
        step(0, 0, 8'h00, 0, 1);
        chk("R8 ack alone", status, 4'h9);

        // Random mix, unlock writes with data[0]=1 only.
        for (int i = 0; i < 3000; i++) begin
            logic a = 1'($urandom_range(0, 3) != 0);
            step(1'($urandom_range(0, 1)), a,
                 a ? {pick_code(), pick_code()} : 8'h01,
                 1'($urandom_range(0, 4) != 0), 1'($urandom_range(0, 1)));
        end
        chk("R7 still unlocked", {3'b0, unlocked}, 4'h1);

        // R7: set bit is harmless, zero locks, later control writes ignored.
        step(1, 0, 8'hFF, 1, 0);
        chk("R7 write one no effect", {3'b0, unlocked}, 4'h1);
        step(1, 0, 8'h00, 1, 0);
        chk("R7 locked", {3'b0, unlocked}, 4'h0);
        step(1, 1, {4'h5, sel == 4'h6 ? 4'h9 : 4'h6}, 1, 0);
        chk("R7 control write ignored", spd, m_spd);
        for (int i = 0; i < 300; i++)
            step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 {pick_code(), pick_code()}, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule